// File: doc/BRIEF.md
# Latched Fault Shutdown Unit

This block guards a bidirectional buck-boost power stage. It compares the sampled input voltage against an upper and a lower limit, the converter output current against a ceiling and the load current against a ceiling. Any limit violation pulls the PWM kill line high in the same cycle, with no register in that path. On the next clock edge the block latches the fault, records the cause and lights the fault indicator.

The latch is sticky. It is released only by an operator clear request that arrives while every monitored quantity is back inside its limits. A clear request given while any limit is still violated has no effect. Each cause keeps its own flag, so when several limits are broken together, all of them are reported. Out of reset the unit starts in the faulted state, so the switches stay off until good samples are present and an operator has cleared the latch.

Top module: `fault_guard`

## Requirements
- R1: During and after synchronous reset, `fault_led` is 1, `cause_flags` is 0 and `pwm_kill` is 1, and they stay so until a clear request is accepted.
- R2: An input voltage strictly greater than `vin_hi_lim` is a violation and sets `cause_flags` bit 0. A value equal to the limit is not a violation.
- R3: An input voltage strictly less than `vin_lo_lim` is a violation and sets `cause_flags` bit 1. A value equal to the limit is not a violation.
- R4: An output current strictly greater than `iout_lim` is a violation and sets `cause_flags` bit 2.
- R5: A load current strictly greater than `iload_lim` is a violation and sets `cause_flags` bit 3.
- R6: `pwm_kill` is 1 in the same cycle in which any violation is present, with no clock edge in between.
- R7: After a clock edge that sees a violation, `fault_led` is 1. While `fault_led` is 1, `pwm_kill` is 1 even when no violation is present.
- R8: A clear request (`fault_clr` = 1) at an edge where any violation is present is ignored. The latch stays set and no flag is cleared.
- R9: A clear request at an edge where no violation is present releases the latch. After that edge, `fault_led`, `cause_flags` and `pwm_kill` are all 0.
- R10: Cause flags are sticky. They remain set after their condition disappears. Simultaneous causes are all recorded, and later causes are added to the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_sample | input | SAMPLE_W | Sampled input voltage code |
| iout_sample | input | SAMPLE_W | Sampled converter output current code |
| iload_sample | input | SAMPLE_W | Sampled load current code |
| vin_hi_lim | input | SAMPLE_W | Input overvoltage limit |
| vin_lo_lim | input | SAMPLE_W | Input undervoltage limit |
| iout_lim | input | SAMPLE_W | Output overcurrent limit |
| iload_lim | input | SAMPLE_W | Load overcurrent limit |
| fault_clr | input | 1 | Operator clear request |
| pwm_kill | output | 1 | Forces all PWM outputs off (combinational) |
| cause_flags | output | 4 | Sticky per-cause flags (bit0 OV, bit1 UV, bit2 output OC, bit3 load OC) |
| fault_led | output | 1 | Registered fault indicator |

## Verification
The bench builds the block with SAMPLE_W = 10. This makes both ends of the code range, 0 and 1023, easy to drive, so every comparator can be pushed to its extremes and to exactly its limit. The limits sit at mid-range values. Each comparator is therefore probed one code inside and one code outside its limit. Several causes can be raised at once with full-scale codes, and a further cause can be added while the latch is already set.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int NCAUSE = 4;
  localparam int C_VIN_OV  = 0;
  localparam int C_VIN_UV  = 1;
  localparam int C_IOUT_OC = 2;
  localparam int C_ILOAD_OC = 3;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int W = 12,
  parameter bit UPPER = 1'b1
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] limit,
  output logic         beyond
);
  generate
    if (UPPER) begin : g_upper
      assign beyond = (sample > limit);
    end else begin : g_lower
      assign beyond = (sample < limit);
    end
  endgenerate
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic release_ok,
  output logic held
);
  // Comes out of reset already holding a fault.
  always_ff @(posedge clk) begin
    if (rst)             held <= 1'b1;
    else if (trip)       held <= 1'b1;
    else if (release_ok) held <= 1'b0;
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
  parameter int SAMPLE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SAMPLE_W-1:0]   vin_sample,
  input  logic [SAMPLE_W-1:0]   iout_sample,
  input  logic [SAMPLE_W-1:0]   iload_sample,
  input  logic [SAMPLE_W-1:0]   vin_hi_lim,
  input  logic [SAMPLE_W-1:0]   vin_lo_lim,
  input  logic [SAMPLE_W-1:0]   iout_lim,
  input  logic [SAMPLE_W-1:0]   iload_lim,
  input  logic                  fault_clr,
  output logic                  pwm_kill,
  output logic [fault_pkg::NCAUSE-1:0] cause_flags,
  output logic                  fault_led
);
  import fault_pkg::*;

  logic [SAMPLE_W-1:0] samp [NCAUSE];
  logic [SAMPLE_W-1:0] lim  [NCAUSE];
  logic [NCAUSE-1:0]   viol;
  logic                any_viol;
  logic                release_ok;
  logic                held;

  assign samp[C_VIN_OV]   = vin_sample;
  assign lim[C_VIN_OV]    = vin_hi_lim;
  assign samp[C_VIN_UV]   = vin_sample;
  assign lim[C_VIN_UV]    = vin_lo_lim;
  assign samp[C_IOUT_OC]  = iout_sample;
  assign lim[C_IOUT_OC]   = iout_lim;
  assign samp[C_ILOAD_OC] = iload_sample;
  assign lim[C_ILOAD_OC]  = iload_lim;

  assign any_viol   = |viol;
  assign release_ok = fault_clr & ~any_viol;

  genvar i;
  generate
    for (i = 0; i < NCAUSE; i++) begin : g_cause
      localparam bit UP = (i != C_VIN_UV);
      limit_cmp #(.W(SAMPLE_W), .UPPER(UP)) u_cmp (
        .sample (samp[i]),
        .limit  (lim[i]),
        .beyond (viol[i])
      );
      sticky_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (viol[i]),
        .clr_i (release_ok),
        .q     (cause_flags[i])
      );
    end
  endgenerate

  fault_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .trip       (any_viol),
    .release_ok (release_ok),
    .held       (held)
  );

  assign fault_led = held;
  assign pwm_kill  = any_viol | held;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] vin_sample,
  input logic [SAMPLE_W-1:0] iout_sample,
  input logic [SAMPLE_W-1:0] iload_sample,
  input logic [SAMPLE_W-1:0] vin_hi_lim,
  input logic [SAMPLE_W-1:0] vin_lo_lim,
  input logic [SAMPLE_W-1:0] iout_lim,
  input logic [SAMPLE_W-1:0] iload_lim,
  input logic                fault_clr,
  input logic                pwm_kill,
  input logic [3:0]          cause_flags,
  input logic                fault_led
);
  logic bad;
  assign bad = (vin_sample > vin_hi_lim) || (vin_sample < vin_lo_lim) ||
               (iout_sample > iout_lim) || (iload_sample > iload_lim);

  // R6
  kill_on_viol_chk: assert property (@(posedge clk) disable iff (rst)
    bad |-> pwm_kill);
  // R7
  led_after_trip_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> fault_led);
  // R7
  kill_while_held_chk: assert property (@(posedge clk) disable iff (rst)
    fault_led |-> pwm_kill);
  // R8
  clr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_clr && bad) |=> fault_led);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_clr && !bad) |=> (!fault_led && cause_flags == 4'b0));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault_clr && !bad) |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));
endmodule

bind fault_guard fault_guard_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_fault_guard.sv
module sim_fault_guard;
  localparam int W = 10;
  localparam logic [W-1:0] HI = 800, LO = 200, IOL = 600, ILL = 700;
  localparam logic [W-1:0] NV = 500, NI = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] vin = NV, iout = NI, iload = NI;
  logic clr = 1'b0;
  logic kill, led;
  logic [3:0] flags;

  always #10 clk = ~clk;

  fault_guard #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .vin_sample(vin), .iout_sample(iout),
    .iload_sample(iload), .vin_hi_lim(HI), .vin_lo_lim(LO),
    .iout_lim(IOL), .iload_lim(ILL), .fault_clr(clr),
    .pwm_kill(kill), .cause_flags(flags), .fault_led(led)
  );

  typedef struct { logic led; logic [3:0] flags; string req; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_err = 0;
  logic m_latch = 1'b1;
  logic [3:0] m_flags = 4'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies a stimulus, checks the combinational kill, queues the
  // registered outcome for the monitor.
  task automatic step(input logic [W-1:0] v, input logic [W-1:0] io,
                      input logic [W-1:0] il, input logic c, input string req);
    logic [3:0] vv;
    exp_t e;
    @(negedge clk);
    #2;
    vin = v; iout = io; iload = il; clr = c;
    #1;
    vv = {il > ILL, io > IOL, v < LO, v > HI};
    chk(kill == ((|vv) | m_latch), req, "pwm_kill", kill, (|vv) | m_latch);
    if (|vv) begin
      m_latch = 1'b1;
      m_flags = m_flags | vv;
    end else if (c) begin
      m_latch = 1'b0;
      m_flags = 4'b0;
    end
    e.led = m_latch; e.flags = m_flags; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: after each edge, compares the registered outputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(led == e.led, e.req, "fault_led", led, e.led);
        chk(flags == e.flags, e.req, "cause_flags", flags, e.flags);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(led == 1'b1, "R1", "fault_led in reset", led, 1);
    chk(flags == 4'b0, "R1", "cause_flags in reset", flags, 0);
    chk(kill == 1'b1, "R1", "pwm_kill in reset", kill, 1);
    @(negedge clk);
    rst = 1'b0;
    step(NV, NI, NI, 0, "R1");         // still held without a clear
    step(NV, NI, NI, 1, "R9");         // release
    step(NV, NI, NI, 0, "R9");
    step(HI, NI, NI, 0, "R2");         // at the limit: no trip
    step(HI + 1, NI, NI, 0, "R2");     // just above: trip bit0
    step(NV, NI, NI, 0, "R7");         // kill held by latch
    step(HI + 1, NI, NI, 1, "R8");     // clear ignored while violating
    step(NV, IOL + 1, NI, 1, "R8");    // different cause, clear ignored
    step(NV, NI, NI, 0, "R10");        // both flags persist
    step(NV, NI, NI, 1, "R9");
    step(LO, NI, NI, 0, "R3");         // at the limit: no trip
    step(LO - 1, NI, NI, 0, "R3");     // below: bit1
    step(NV, NI, NI, 1, "R9");
    step(NV, IOL, NI, 0, "R4");        // at limit: no trip
    step(NV, IOL + 1, NI, 0, "R4");    // bit2
    step(NV, NI, NI, 1, "R9");
    step(NV, NI, ILL, 0, "R5");
    step(NV, NI, ILL + 1, 0, "R5");    // bit3
    step(NV, NI, NI, 1, "R9");
    step(10'd1023, 10'd1023, 10'd1023, 0, "R10"); // three at once
    step(10'd0, NI, NI, 0, "R10");     // adds UV on top
    step(NV, NI, NI, 0, "R10");
    step(NV, NI, NI, 1, "R9");
    step(NV, NI, NI, 0, "R6");
    step(NV, NI, ILL + 1, 0, "R6");    // kill in the same cycle
    repeat (3) @(negedge clk);
    #3;
    chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule